// File: doc/BRIEF.md
# Register-Mapped Interrupt Aggregator

The block gathers a parameterised number of interrupt lines (up to 32) into a single request for a processor. Each line latches into a status register. A line is sampled as a rising edge or as a level, and the choice is fixed per line when the block is built. Software reaches the block through a small word-addressed register bus. The bus has a write strobe, a write-data bus and a combinational read-data bus.

An enable mask selects which latched lines may raise the request. Enable bits can be written directly, or set and cleared individually through two alias registers, so a handler never needs a read-modify-write. A handler reads the vector register to find the lowest-numbered enabled line that is waiting. It services that line and clears its latch by writing a one to the acknowledge register. It keeps doing this until the vector register reads all ones.

A two-bit master register gates the request output and gates hardware capture of the inputs. While hardware capture is off, software may write ones into the status register to inject interrupts for testing.

Top module: `irq_hub`

## Requirements
- R1: After a synchronous active-low reset, status, enable and master registers read zero, the vector register reads 0xFFFFFFFF and `irq_req` is low.
- R2: A level-kind line (build mask bit 0) sets its status bit on every clock edge where it is high and hardware capture is on. The bit stays set after the line drops, until it is acknowledged.
- R3: An edge-kind line (build mask bit 1) sets its status bit only on a clock edge where it is high and it was low on the previous edge. A held-high or falling line does not set it again. Mask bits at or above the line count have no effect.
- R4: Writing the set-enable register ORs the write data into the enable mask. Writing the clear-enable register clears the bits that are one in the data. A write to the enable register replaces the mask. Enable bits at or above the line count read zero.
- R5: Writing ones to the acknowledge register clears those status bits. If an acknowledge and a new capture hit the same bit on the same edge, the acknowledge wins, so a level line that is still high latches again one cycle later.
- R6: The pending register reads status AND enable. `irq_req` is high exactly when master bit 0 is set and pending is nonzero.
- R7: The vector register reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when pending is zero.
- R8: Master bit 0 gates the request output and master bit 1 turns on hardware capture; the register reads back exactly what was written to those two bits. While bit 1 is clear, input lines are not captured and status writes OR ones into status. While bit 1 is set, status writes are ignored.
- R9: Byte offsets on `bus_addr`: status 0x00, pending 0x04, enable 0x08, acknowledge 0x0C, set-enable 0x10, clear-enable 0x14, vector 0x18, master 0x1C. Offsets 0x0C, 0x10 and 0x14 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt lines |
| bus_addr | input | 5 | Byte address of the register; bits 1:0 are ignored |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with 12 lines. The edge mask marks lines 4 to 7 as edge kind, and it also sets bits 12 to 15, which lie above the line count. This gives level and edge lines side by side. It also lets a set-enable of all ones show that bits above the line count stay clear. Line 11 exercises the top of the vector range. Line 5 shows that a falling edge, or a line held high after an acknowledge, does not latch again.

// File: rtl/irq_hub_pkg.sv
// Package: shared register selector encoding and constants for irq_hub.
// Assumes the bus carries byte addresses with 32-bit word registers.
package irq_hub_pkg;

    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] NO_VECTOR = '1;

    // Word index (byte offset / 4) of each register; software depends on it.
    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_PENDING = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_ACK     = 3'd3,
        SEL_SET_EN  = 3'd4,
        SEL_CLR_EN  = 3'd5,
        SEL_VECTOR  = 3'd6,
        SEL_MASTER  = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/irq_hub_capture.sv
// Module: irq_hub_capture
// Latches each interrupt line into a status bit. Each line is edge or level
// kind according to EDGE_MASK. Acknowledge has priority over a capture or a
// software set on the same edge. Assumes irq_in is synchronous to clk.
module irq_hub_capture #(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               hw_en,
    input  logic [NUM_SRC-1:0] sw_set,
    input  logic [NUM_SRC-1:0] ack,
    output logic [NUM_SRC-1:0] status_q
);

    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
        if (EDGE_MASK[i]) begin : g_edge
            logic prev_q;
            // Keep last cycle's level of this line for rising-edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= irq_in[i];
            end
            assign hit[i] = irq_in[i] & ~prev_q;
        end else begin : g_level
            assign hit[i] = irq_in[i];
        end
    end

    // Merge hardware hits and software sets, then apply acknowledge last.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q | (hw_en ? hit : '0) | sw_set) & ~ack;
    end

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack != '0) |=> ((status_q & $past(ack)) == '0));

    assert_no_capture_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_en && sw_set == '0) |=> ((status_q & ~$past(status_q)) == '0));

endmodule

// File: rtl/irq_hub_enable.sv
// Module: irq_hub_enable
// Holds the enable mask and accepts a direct write, a set alias and a clear
// alias. Assumes at most one of the three write strobes is high per cycle.
module irq_hub_enable #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_direct,
    input  logic               wr_set,
    input  logic               wr_clr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] enable_q
);

    // Update the mask from whichever write form is active.
    always_ff @(posedge clk) begin
        if (!rst_n)         enable_q <= '0;
        else if (wr_direct) enable_q <= wdata;
        else if (wr_set)    enable_q <= enable_q | wdata;
        else if (wr_clr)    enable_q <= enable_q & ~wdata;
    end

    assert_set_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((enable_q & $past(wdata)) == $past(wdata)));

    assert_clr_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((enable_q & $past(wdata)) == '0));

endmodule

// File: rtl/irq_hub_pick.sv
// Module: irq_hub_pick
// Finds the lowest-numbered set bit of a request vector. Purely
// combinational; assumes IDX_W is wide enough to hold NUM_SRC-1.
module irq_hub_pick #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    // Scan from the top so that the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_hub.sv
// Module: irq_hub (top)
// Register-mapped interrupt aggregator: decodes the register bus, holds the
// master bits and drives the request output. Assumes NUM_SRC <= 32 and one
// bus access per cycle; reads are combinational.
module irq_hub #(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [4:0]         bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_req
);
    import irq_hub_pkg::*;

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [NUM_SRC-1:0] ONES = '1;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] wsrc;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] pending;
    logic [1:0]         master_q;
    logic               vec_found;
    logic [IDX_W-1:0]   vec_idx;
    logic               unused_bus;

    assign sel        = reg_sel_e'(bus_addr[4:2]);
    assign wsrc       = bus_wdata[NUM_SRC-1:0];
    assign unused_bus = ^{bus_addr[1:0], bus_wdata};

    // Master bits: bit 0 gates the request, bit 1 turns on hardware capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                             master_q <= 2'b00;
        else if (bus_we && sel == SEL_MASTER)   master_q <= bus_wdata[1:0];
    end

    irq_hub_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .hw_en    (master_q[1]),
        .sw_set   ((bus_we && sel == SEL_STATUS && !master_q[1]) ? wsrc : '0),
        .ack      ((bus_we && sel == SEL_ACK) ? wsrc : '0),
        .status_q (status_q)
    );

    irq_hub_enable #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_direct (bus_we && sel == SEL_ENABLE),
        .wr_set    (bus_we && sel == SEL_SET_EN),
        .wr_clr    (bus_we && sel == SEL_CLR_EN),
        .wdata     (wsrc),
        .enable_q  (enable_q)
    );

    assign pending = status_q & enable_q;
    assign irq_req = master_q[0] & (|pending);

    irq_hub_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .pend  (pending),
        .found (vec_found),
        .idx   (vec_idx)
    );

    // Read mux: registers narrower than 32 bits are zero-extended.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_STATUS:  bus_rdata[NUM_SRC-1:0] = status_q;
            SEL_PENDING: bus_rdata[NUM_SRC-1:0] = pending;
            SEL_ENABLE:  bus_rdata[NUM_SRC-1:0] = enable_q;
            SEL_VECTOR:  bus_rdata = vec_found ? DATA_W'(vec_idx) : NO_VECTOR;
            SEL_MASTER:  bus_rdata[1:0] = master_q;
            default:     bus_rdata = '0;
        endcase
    end

    assert_req_low_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !irq_req);

    assert_vec_is_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_found |-> pending[vec_idx]);

    assert_vec_is_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_found |-> ((pending & ~(ONES << vec_idx)) == '0));

endmodule

// File: tb/test_irq_hub.sv
// Bench for irq_hub: a table of stimulus/expectation steps walked by one
// loop, then directed reset checks. Each step is one clock cycle.
module test_irq_hub;

    localparam int N = 12;
    localparam logic [31:0] EMASK = 32'h0000_F0F0;

    // Step fields: rq tag, irq_in, write strobe, write addr, write data,
    // read addr, expected read data, expected irq_req.
    localparam int SW = 4 + N + 1 + 5 + 32 + 5 + 32 + 1;
    localparam int NSTEP = 29;
    localparam logic [SW-1:0] STEPS [NSTEP] = '{
        {4'd8, 12'h000, 1'b1, 5'h1C, 32'h3,        5'h1C, 32'h3,        1'b0}, // R8 master readback
        {4'd2, 12'h001, 1'b0, 5'h00, 32'h0,        5'h00, 32'h001,      1'b0}, // R2 level latch
        {4'd4, 12'h001, 1'b1, 5'h10, 32'h003,      5'h08, 32'h003,      1'b1}, // R4 set alias
        {4'd4, 12'h001, 1'b1, 5'h10, 32'h010,      5'h08, 32'h013,      1'b1}, // R4 set alias OR
        {4'd4, 12'h001, 1'b1, 5'h14, 32'h002,      5'h08, 32'h011,      1'b1}, // R4 clear alias
        {4'd6, 12'h001, 1'b0, 5'h00, 32'h0,        5'h04, 32'h001,      1'b1}, // R6 pending
        {4'd3, 12'h011, 1'b0, 5'h00, 32'h0,        5'h00, 32'h011,      1'b1}, // R3 rising edge
        {4'd7, 12'h011, 1'b0, 5'h00, 32'h0,        5'h18, 32'h0,        1'b1}, // R7 lowest wins
        {4'd2, 12'h010, 1'b1, 5'h0C, 32'h001,      5'h00, 32'h010,      1'b1}, // R2 ack after drop
        {4'd7, 12'h010, 1'b0, 5'h00, 32'h0,        5'h18, 32'h4,        1'b1}, // R7 vector 4
        {4'd3, 12'h010, 1'b1, 5'h0C, 32'h010,      5'h00, 32'h000,      1'b0}, // R3 held high no relatch
        {4'd7, 12'h000, 1'b0, 5'h00, 32'h0,        5'h18, 32'hFFFF_FFFF,1'b0}, // R7 none pending
        {4'd2, 12'h001, 1'b0, 5'h00, 32'h0,        5'h00, 32'h001,      1'b1}, // R2 latch again
        {4'd5, 12'h001, 1'b1, 5'h0C, 32'h001,      5'h00, 32'h000,      1'b0}, // R5 ack wins
        {4'd5, 12'h001, 1'b0, 5'h00, 32'h0,        5'h00, 32'h001,      1'b1}, // R5 relatch next cycle
        {4'd8, 12'h000, 1'b1, 5'h1C, 32'h1,        5'h00, 32'h001,      1'b1}, // R8 capture off
        {4'd8, 12'h002, 1'b0, 5'h00, 32'h0,        5'h00, 32'h001,      1'b1}, // R8 input ignored
        {4'd8, 12'h000, 1'b1, 5'h00, 32'h0C0,      5'h00, 32'h0C1,      1'b1}, // R8 software set
        {4'd6, 12'h000, 1'b1, 5'h1C, 32'h2,        5'h00, 32'h0C1,      1'b0}, // R6 request gated
        {4'd8, 12'h000, 1'b1, 5'h00, 32'h002,      5'h00, 32'h0C1,      1'b0}, // R8 status write ignored
        {4'd4, 12'h000, 1'b1, 5'h08, 32'h0,        5'h04, 32'h000,      1'b0}, // R4 direct write
        {4'd5, 12'h000, 1'b1, 5'h0C, 32'hFFFF_FFFF,5'h00, 32'h000,      1'b0}, // R5 ack all
        {4'd2, 12'h800, 1'b1, 5'h1C, 32'h3,        5'h00, 32'h800,      1'b0}, // R2 top line
        {4'd4, 12'h800, 1'b1, 5'h10, 32'hFFFF_FFFF,5'h08, 32'hFFF,      1'b1}, // R4 upper bits zero
        {4'd7, 12'h800, 1'b0, 5'h00, 32'h0,        5'h18, 32'hB,        1'b1}, // R7 vector 11
        {4'd3, 12'h820, 1'b0, 5'h00, 32'h0,        5'h00, 32'h820,      1'b1}, // R3 edge line 5
        {4'd3, 12'h820, 1'b1, 5'h0C, 32'h020,      5'h00, 32'h800,      1'b1}, // R3 held, no relatch
        {4'd3, 12'h800, 1'b0, 5'h00, 32'h0,        5'h00, 32'h800,      1'b1}, // R3 falling no latch
        {4'd9, 12'h800, 1'b0, 5'h00, 32'h0,        5'h0C, 32'h0,        1'b1}  // R9 ack reads zero
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [4:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_req;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    irq_hub #(.NUM_SRC(N), .EDGE_MASK(EMASK)) i_irq_hub (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req)
    );

    task automatic check(input int rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic peek(input logic [4:0] addr, input int rq, input string what,
                        input logic [31:0] exp);
        bus_addr = addr;
        #1;
        check(rq, what, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        peek(5'h00, 1, "status after reset", 32'h0);
        peek(5'h08, 1, "enable after reset", 32'h0);
        peek(5'h1C, 1, "master after reset", 32'h0);
        peek(5'h18, 1, "vector after reset", 32'hFFFF_FFFF);
        check(1, "irq_req after reset", {31'b0, irq_req}, 32'h0);

        for (int s = 0; s < NSTEP; s++) begin
            logic [SW-1:0] st;
            st = STEPS[s];
            irq_in    = st[SW-5 -: N];
            bus_we    = st[SW-5-N];
            bus_addr  = st[SW-6-N -: 5];
            bus_wdata = st[SW-11-N -: 32];
            @(posedge clk);
            #1 bus_we = 1'b0;
            bus_addr = st[37:33];
            #1;
            check(int'(st[SW-1 -: 4]), $sformatf("step %0d rdata", s), bus_rdata, st[32:1]);
            check(int'(st[SW-1 -: 4]), $sformatf("step %0d irq_req", s), {31'b0, irq_req}, {31'b0, st[0]});
        end

        // R1 reset in mid-run clears everything while a level line stays high.
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
        peek(5'h00, 1, "status after mid reset", 32'h0);
        peek(5'h08, 1, "enable after mid reset", 32'h0);
        peek(5'h1C, 1, "master after mid reset", 32'h0);
        check(1, "irq_req after mid reset", {31'b0, irq_req}, 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule